// File: doc/BRIEF.md
# Receive FIFO with Per-Entry Error Tags

This block is the receive-side queue of a serial port. A receiver shifter hands it one byte at a time along with three error tags (parity, framing, break). Each tag is stored with its byte. A CPU-style read port removes bytes from the head of the queue.

The line-status interrupt is driven from the tags of the byte at the head of the queue, not from the byte most recently written. An errored byte therefore raises the interrupt only once software has read every byte in front of it. A read strobe on the line status register silences the interrupt for the current head entry. A running count of tagged entries gives a summary error flag. That flag stays set while any errored byte remains anywhere in the queue.

A selectable trigger level raises a data-ready indication once enough bytes are stored. A flush input empties the queue.

Both data interfaces use valid/ready. On the write side, `in_ready` is low only when the queue is full. A shifter cannot stall, so `in_valid` held while `in_ready` is low does not wait. That byte is discarded and the overrun flag is set.

On the read side, the head byte is on `out_data` whenever `out_valid` is high. It is removed on a clock edge where both `out_valid` and `out_ready` are high.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset, `out_valid`, `err_any`, `overrun`, `ls_irq` and `data_irq` are 0, and `in_ready` is 1.
- R2: Bytes leave in the order they were accepted. `out_valid` is high exactly when the queue holds at least one byte. `in_ready` goes low once 16 bytes are stored.
- R3: An `in_valid` cycle while `in_ready` is low discards the byte and sets `overrun` from the next cycle. `overrun` clears in the cycle after an `lsr_rd` strobe.
- R4: `head_par`, `head_frm` and `head_brk` show the tags of the byte on `out_data`, and are 0 when the queue is empty.
- R5: `ls_irq` is high only while the head entry carries at least one tag and `lsr_ie` is 1. Writing a tagged byte behind a clean head does not raise it.
- R6: An `lsr_rd` strobe drops `ls_irq` from the next cycle. It stays low while the same entry remains at the head. It rises again when a pop brings a different tagged entry to the head.
- R7: `err_any` is 1 while at least one tagged byte is stored anywhere in the queue, and 0 otherwise.
- R8: `data_irq` is 1 when the stored count is at least the trigger level. `trig_sel` selects the level: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14.
- R9: A `flush` cycle forces `ls_irq` low in that cycle. From the next cycle the queue is empty and `err_any` is 0. A byte offered in a flush cycle is dropped without setting `overrun`.
- R10: With `lsr_ie` at 0, `ls_irq` stays low whatever the head entry holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Shifter offers a byte |
| in_ready | output | 1 | Queue has room |
| in_data | input | 8 | Received byte |
| in_par_err | input | 1 | Parity error tag of the offered byte |
| in_frm_err | input | 1 | Framing error tag of the offered byte |
| in_brk | input | 1 | Break tag of the offered byte |
| out_valid | output | 1 | Head byte available |
| out_ready | input | 1 | Reader takes the head byte |
| out_data | output | 8 | Head byte |
| head_par | output | 1 | Parity tag of the head byte |
| head_frm | output | 1 | Framing tag of the head byte |
| head_brk | output | 1 | Break tag of the head byte |
| err_any | output | 1 | Some stored byte carries a tag |
| overrun | output | 1 | A byte was lost to a full queue |
| lsr_rd | input | 1 | Line status register read strobe |
| lsr_ie | input | 1 | Line-status interrupt enable |
| ls_irq | output | 1 | Line-status interrupt |
| trig_sel | input | 2 | Trigger level select |
| data_irq | output | 1 | Stored count has reached the trigger level |
| flush | input | 1 | Empty the queue |

## Verification
The bench places a tagged byte behind a clean one. A design that raised the interrupt on the write, rather than on arrival at the head, would show `ls_irq` high too early.

After a status read, it pushes a second tagged byte while the first is still at the head. A design that re-armed on any push would re-assert the interrupt before the head moves.

It fills the queue to 16 and offers one more byte. A design that overwrote instead of discarding would corrupt the drain order or miss the overrun.

It also steps each trigger level across its threshold, and flushes with tagged entries still stored. This catches off-by-one compares and a stale error count left behind by a flush.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       par;
    logic       frm;
    logic       brk;
  } rxf_entry_t;

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = 5'd1;
      2'd1:    trig_level = 5'd4;
      2'd2:    trig_level = 5'd8;
      default: trig_level = 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  push,
  input  logic                  pop,
  input  rxf_pkg::rxf_entry_t   wr_ent,
  output rxf_pkg::rxf_entry_t   rd_ent,
  output logic [CW-1:0]         count
);
  rxf_pkg::rxf_entry_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_ptr == AW'(i)) mem[i] <= wr_ent;
    end
  end

  assign rd_ent = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0); // R9
endmodule

// File: rtl/rxf_errcnt.sv
module rxf_errcnt #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          push_err,
  input  logic          pop,
  input  logic          pop_err,
  input  logic [CW-1:0] count,
  output logic          err_any
);
  logic [CW-1:0] err_cnt;
  logic inc, dec;

  assign inc = push && push_err;
  assign dec = pop && pop_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_cnt <= '0;
    else if (flush)   err_cnt <= '0;
    else if (inc && !dec) err_cnt <= err_cnt + 1'b1;
    else if (dec && !inc) err_cnt <= err_cnt - 1'b1;
  end

  assign err_any = err_cnt != '0;

  AST_ERRCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= count); // R7
endmodule

// File: rtl/rxf_lsi.sv
module rxf_lsi (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic empty,
  input  logic pop,
  input  logic head_err,
  input  logic lsr_rd,
  input  logic lsr_ie,
  input  logic ovr_evt,
  output logic overrun,
  output logic ls_irq
);
  logic hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hold <= 1'b0;
    else if (flush || pop || empty)   hold <= 1'b0;
    else if (lsr_rd)                  hold <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (ovr_evt) overrun <= 1'b1;
    else if (lsr_rd)  overrun <= 1'b0;
  end

  assign ls_irq = lsr_ie && head_err && !hold && !flush;

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !pop && !empty) |=> !ls_irq); // R6
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ovr_evt) |=> !overrun); // R3
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_par_err,
  input  logic       in_frm_err,
  input  logic       in_brk,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       head_par,
  output logic       head_frm,
  output logic       head_brk,
  output logic       err_any,
  output logic       overrun,
  input  logic       lsr_rd,
  input  logic       lsr_ie,
  output logic       ls_irq,
  input  logic [1:0] trig_sel,
  output logic       data_irq,
  input  logic       flush
);
  rxf_pkg::rxf_entry_t wr_ent, rd_ent;
  logic [CW-1:0] count;
  logic push, pop, full, empty, head_err, ovr_evt;

  assign full      = count == CW'(DEPTH);
  assign empty     = count == '0;
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign push      = in_valid && !full && !flush;
  assign pop       = out_valid && out_ready && !flush;
  assign ovr_evt   = in_valid && full && !flush;

  assign wr_ent = '{data: in_data, par: in_par_err, frm: in_frm_err, brk: in_brk};

  assign out_data = rd_ent.data;
  assign head_par = out_valid && rd_ent.par;
  assign head_frm = out_valid && rd_ent.frm;
  assign head_brk = out_valid && rd_ent.brk;
  assign head_err = head_par || head_frm || head_brk;

  assign data_irq = count >= CW'(rxf_pkg::trig_level(trig_sel));

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
    .wr_ent(wr_ent), .rd_ent(rd_ent), .count(count)
  );

  rxf_errcnt #(.DEPTH(DEPTH)) u_errcnt (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(push), .push_err(in_par_err || in_frm_err || in_brk),
    .pop(pop), .pop_err(head_err), .count(count), .err_any(err_any)
  );

  rxf_lsi u_lsi (
    .clk(clk), .rst_n(rst_n), .flush(flush), .empty(empty), .pop(pop),
    .head_err(head_err), .lsr_rd(lsr_rd), .lsr_ie(lsr_ie),
    .ovr_evt(ovr_evt), .overrun(overrun), .ls_irq(ls_irq)
  );

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !flush) |=> overrun); // R3
  AST_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !err_any); // R7
endmodule

// File: tb/tb_rx_err_fifo.sv
module tb_rx_err_fifo;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_par_err = 0, in_frm_err = 0, in_brk = 0;
  logic [7:0] in_data = 0;
  logic out_ready = 0, lsr_rd = 0, lsr_ie = 0, flush = 0;
  logic [1:0] trig_sel = 0;
  logic in_ready, out_valid, head_par, head_frm, head_brk;
  logic err_any, overrun, ls_irq, data_irq;
  logic [7:0] out_data;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_fifo dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; out_ready = 0; lsr_rd = 0; flush = 0;
    in_par_err = 0; in_frm_err = 0; in_brk = 0;
    #1;
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] tags);
    @(negedge clk);
    in_valid = 1; in_data = d;
    {in_par_err, in_frm_err, in_brk} = tags;
    idle();
  endtask

  task automatic pop_expect(input string req, input logic [7:0] d);
    @(negedge clk);
    #1;
    chk(req, out_data, d);
    out_ready = 1;
    idle();
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) lsr_rd = 1; else flush = 1;
    #1;
    if (which == 1) chk("R9 irq drops in flush cycle", ls_irq, 0);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 out_valid", out_valid, 0);
    chk("R1 err_any", err_any, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 ls_irq", ls_irq, 0);
    chk("R1 data_irq", data_irq, 0);
    chk("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_head_irq();
    lsr_ie = 1;
    push(8'h11, 3'b000);
    push(8'h22, 3'b100);
    chk("R5 tagged byte behind clean head", ls_irq, 0);
    chk("R7 err_any with tag stored", err_any, 1);
    chk("R4 clean head tags", head_par, 0);
    pop_expect("R2 first byte", 8'h11);
    chk("R5 irq at errored head", ls_irq, 1);
    chk("R4 head_par", head_par, 1);
    pulse(0);
    chk("R6 irq cleared by status read", ls_irq, 0);
    push(8'h33, 3'b010);
    idle();
    chk("R6 irq stays clear for same head", ls_irq, 0);
    pop_expect("R2 second byte", 8'h22);
    chk("R6 irq re-asserts on new errored head", ls_irq, 1);
    chk("R4 head_frm", head_frm, 1);
    chk("R4 head_par of new head", head_par, 0);
    pop_expect("R2 third byte", 8'h33);
    chk("R7 err_any after drain", err_any, 0);
    chk("R4 tags zero when empty", head_frm, 0);
    chk("R5 irq low when empty", ls_irq, 0);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 16; i++) push(8'(8'h40 + i), 3'b000);
    chk("R2 in_ready low when full", in_ready, 0);
    chk("R3 no overrun yet", overrun, 0);
    push(8'hEE, 3'b001);
    chk("R3 overrun set", overrun, 1);
    chk("R7 dropped tag not counted", err_any, 0);
    for (int i = 0; i < 16; i++) pop_expect("R2 drain order", 8'(8'h40 + i));
    chk("R3 dropped byte not stored", out_valid, 0);
    pulse(0);
    chk("R3 overrun cleared by status read", overrun, 0);
  endtask

  task automatic t_trigger();
    int lv [4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int i = 0; i < lv[s] - 1; i++) push(8'(i), 3'b000);
      chk($sformatf("R8 below level sel=%0d", s), data_irq, 0);
      push(8'hA5, 3'b000);
      chk($sformatf("R8 at level sel=%0d", s), data_irq, 1);
      pulse(1);
    end
  endtask

  task automatic t_flush();
    lsr_ie = 1;
    push(8'h01, 3'b001);
    push(8'h02, 3'b100);
    chk("R5 irq before flush", ls_irq, 1);
    @(negedge clk);
    flush = 1; in_valid = 1; in_data = 8'h77;
    #1;
    chk("R9 irq drops in flush cycle", ls_irq, 0);
    idle();
    chk("R9 empty after flush", out_valid, 0);
    chk("R9 err_any cleared", err_any, 0);
    chk("R9 no overrun from flush-cycle byte", overrun, 0);
  endtask

  task automatic t_mask();
    lsr_ie = 0;
    push(8'h5A, 3'b010);
    chk("R10 masked irq", ls_irq, 0);
    lsr_ie = 1;
    #1;
    chk("R10 irq once enabled", ls_irq, 1);
    pulse(1);
  endtask

  initial begin
    #(CLK_PERIOD * 500000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1;
    idle();
    t_head_irq();
    t_overrun();
    t_trigger();
    t_flush();
    t_mask();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule